// File: doc/BRIEF.md
# Byte-Masked Write-Combining Line Buffer

This block collects streaming stores, each carrying a line address, a full line of data and one enable bit per byte, into a single 64-byte staging line. It keeps one valid bit per byte. A store is accepted straight into the line and no request goes to peer caches before that. A later store to the same byte replaces the earlier value.

The block drains the line in one of two ways. If every byte has been written, it sends an invalidate to peer caches and then writes the whole line to memory. Any dirty peer copy is dropped, because nothing in it survives. If the line is only partly written when it is reclaimed, the block asks the peers for the line. Reclaim happens on a flush request, or when a store arrives for a different line address. If the peer response is dirty, the buffered bytes are laid over the peer data and the whole line is written with every mask bit set. If the response is clean, only the written bytes go out as a masked write, and the bytes that are masked off keep their old value in memory.

The controller has five states:
- `WCB_IDLE`: empty.
- `WCB_ACCUM`: holding bytes.
- `WCB_INVAL`: full-line invalidate.
- `WCB_SNOOP`: waiting for the peer response.
- `WCB_WRITE`: one-cycle memory write.

Transitions:
- IDLE→ACCUM: a store with at least one enabled byte is accepted.
- ACCUM→INVAL: all bytes are valid. This has priority over the other ACCUM exits.
- ACCUM→SNOOP: a flush, or a store to another line.
- INVAL→WRITE: always, after one cycle.
- SNOOP→WRITE: a peer response arrives.
- WRITE→IDLE: always.

Top module: `wcb_line_buffer`

## Requirements
- R1: `st_ready` is high in IDLE. In ACCUM it is high only when the line is not full, no flush is requested and `st_line` equals the held line. It is low in INVAL, SNOOP and WRITE. An accepted store writes exactly the bytes whose `st_be` bit is 1 (bit i covers data bits 8i+7..8i).
- R2: `snp_req` and `inv_req` are never high in a cycle in which a store is accepted, so no peer request comes before store data.
- R3: One cycle after the last byte becomes valid, `inv_req` is high for one cycle with `inv_line` set to the line. In the next cycle `mem_valid` is high for one cycle, `mem_mask` is all ones and `mem_data` holds the stored bytes.
- R4: The full-line drain issues no `snp_req`, and peer snoop data has no effect on its `mem_data`.
- R5: On a partial drain, `snp_req` goes high with `snp_line` set to the held line, and both stay steady until `snp_valid` is seen.
- R6: A response with `snp_dirty`=1 leads, one cycle later, to a write with `mem_mask` all ones. Each written byte keeps the buffer value and every other byte takes `snp_data`.
- R7: A response with `snp_dirty`=0 leads, one cycle later, to a write whose `mem_mask` equals the per-byte valid set. The data in the masked bytes is the stored data.
- R8: A store to a different line while bytes are held drains the current line first. The new store is accepted after that write, into an empty buffer.
- R9: When several stores hit the same byte before a drain, the last one wins.
- R10: After every write the valid bits clear, the controller returns to IDLE and `st_ready` is high. A flush in IDLE is ignored. A store with no enabled bytes leaves the buffer in IDLE.
- R11: After reset `st_ready`=1 and `snp_req`, `inv_req` and `mem_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store present |
| st_ready | output | 1 | Store accepted this cycle if valid |
| st_line | input | LINE_AW | Store line address |
| st_data | input | 8*LINE_BYTES | Store data, byte i at bits 8i+7..8i |
| st_be | input | LINE_BYTES | Store byte enables |
| flush_req | input | 1 | Reclaim request for the held line |
| snp_req | output | 1 | Request peer copy of held line |
| snp_line | output | LINE_AW | Line address of the peer request |
| snp_valid | input | 1 | Peer response present |
| snp_dirty | input | 1 | Peer holds a dirty copy |
| snp_data | input | 8*LINE_BYTES | Peer line data |
| inv_req | output | 1 | Invalidate peer copies (full-line drain) |
| inv_line | output | LINE_AW | Line address to invalidate |
| mem_valid | output | 1 | Memory write present (one cycle) |
| mem_line | output | LINE_AW | Memory write line address |
| mem_data | output | 8*LINE_BYTES | Memory write data |
| mem_mask | output | LINE_BYTES | Memory write byte mask |

## Verification
A corrupted valid bit appears at the ports on the next drain, at the latest. It shows as a wrong `mem_mask` on a clean partial write, as a partial drain where a full one was expected, or as a stuck controller that never asserts `inv_req`. A wrong controller state shows within one cycle: `st_ready`, `snp_req`, `inv_req` and `mem_valid` no longer form the expected sequence. A merge fault shows only in the `mem_data` of the write that follows a dirty response. The bench therefore compares every write against a reference line kept from the stores it issued.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    typedef enum logic [2:0] {
        WCB_IDLE,
        WCB_ACCUM,
        WCB_INVAL,
        WCB_SNOOP,
        WCB_WRITE
    } wcb_state_e;
endpackage

// File: rtl/wcb_line_store.sv
module wcb_line_store #(
    parameter int LINE_BYTES = 64,
    localparam int DATA_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [LINE_BYTES-1:0] wr_be,
    input  logic                  fill_en,
    input  logic [DATA_W-1:0]     fill_data,
    output logic [DATA_W-1:0]     line_data,
    output logic [LINE_BYTES-1:0] line_valid,
    output logic                  line_full
);
    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
        // valid bit: set by a store, cleared after the drain write
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                line_valid[g] <= 1'b0;
            else if (clr)
                line_valid[g] <= 1'b0;
            else if (wr_en && wr_be[g])
                line_valid[g] <= 1'b1;
        end

        // data byte: store data wins, peer fill only where never written
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                line_data[g*8 +: 8] <= '0;
            else if (wr_en && wr_be[g])
                line_data[g*8 +: 8] <= wr_data[g*8 +: 8];
            else if (fill_en && !line_valid[g])
                line_data[g*8 +: 8] <= fill_data[g*8 +: 8];
        end
    end

    assign line_full = &line_valid;
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
    import wcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic st_valid,
    input  logic st_hit,
    input  logic st_be_any,
    input  logic line_full,
    input  logic flush_req,
    input  logic snp_valid,
    input  logic snp_dirty,
    output logic st_ready,
    output logic st_accept,
    output logic load_line,
    output logic snp_req,
    output logic inv_req,
    output logic mem_valid,
    output logic fill_en,
    output logic clr,
    output logic mask_all
);
    wcb_state_e state, nxt;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            WCB_IDLE:  if (st_valid && st_be_any) nxt = WCB_ACCUM;
            WCB_ACCUM: begin
                if (line_full)
                    nxt = WCB_INVAL;
                else if (flush_req || (st_valid && !st_hit))
                    nxt = WCB_SNOOP;
            end
            WCB_INVAL: nxt = WCB_WRITE;
            WCB_SNOOP: if (snp_valid) nxt = WCB_WRITE;
            WCB_WRITE: nxt = WCB_IDLE;
            default:   nxt = WCB_IDLE;
        endcase
    end

    // state register and mask-all flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= WCB_IDLE;
            mask_all <= 1'b0;
        end else begin
            state <= nxt;
            if (state == WCB_ACCUM && nxt == WCB_INVAL)
                mask_all <= 1'b1;
            else if (state == WCB_SNOOP && snp_valid)
                mask_all <= snp_dirty;
        end
    end

    // outputs decoded from state
    always_comb begin
        st_ready  = 1'b0;
        snp_req   = 1'b0;
        inv_req   = 1'b0;
        mem_valid = 1'b0;
        fill_en   = 1'b0;
        clr       = 1'b0;
        load_line = 1'b0;
        unique case (state)
            WCB_IDLE: begin
                st_ready  = 1'b1;
                load_line = st_valid;
            end
            WCB_ACCUM: st_ready = !line_full && !flush_req && st_hit;
            WCB_INVAL: inv_req = 1'b1;
            WCB_SNOOP: begin
                snp_req = 1'b1;
                fill_en = snp_valid && snp_dirty;
            end
            WCB_WRITE: begin
                mem_valid = 1'b1;
                clr       = 1'b1;
            end
            default: ;
        endcase
        st_accept = st_valid && st_ready;
    end
endmodule

// File: rtl/wcb_line_buffer.sv
module wcb_line_buffer #(
    parameter int LINE_BYTES = 64,
    parameter int LINE_AW    = 26,
    localparam int DATA_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [LINE_AW-1:0]    st_line,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [LINE_BYTES-1:0] st_be,
    input  logic                  flush_req,
    output logic                  snp_req,
    output logic [LINE_AW-1:0]    snp_line,
    input  logic                  snp_valid,
    input  logic                  snp_dirty,
    input  logic [DATA_W-1:0]     snp_data,
    output logic                  inv_req,
    output logic [LINE_AW-1:0]    inv_line,
    output logic                  mem_valid,
    output logic [LINE_AW-1:0]    mem_line,
    output logic [DATA_W-1:0]     mem_data,
    output logic [LINE_BYTES-1:0] mem_mask
);
    logic [LINE_AW-1:0]    cur_line;
    logic [LINE_BYTES-1:0] line_valid;
    logic                  line_full, st_accept, load_line;
    logic                  fill_en, clr, mask_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_line <= '0;
        else if (load_line)
            cur_line <= st_line;
    end

    wcb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_hit    (st_line == cur_line),
        .st_be_any (|st_be),
        .line_full (line_full),
        .flush_req (flush_req),
        .snp_valid (snp_valid),
        .snp_dirty (snp_dirty),
        .st_ready  (st_ready),
        .st_accept (st_accept),
        .load_line (load_line),
        .snp_req   (snp_req),
        .inv_req   (inv_req),
        .mem_valid (mem_valid),
        .fill_en   (fill_en),
        .clr       (clr),
        .mask_all  (mask_all)
    );

    wcb_line_store #(.LINE_BYTES(LINE_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .wr_en      (st_accept),
        .wr_data    (st_data),
        .wr_be      (st_be),
        .fill_en    (fill_en),
        .fill_data  (snp_data),
        .line_data  (mem_data),
        .line_valid (line_valid),
        .line_full  (line_full)
    );

    assign snp_line = cur_line;
    assign inv_line = cur_line;
    assign mem_line = cur_line;
    assign mem_mask = mask_all ? {LINE_BYTES{1'b1}} : line_valid;
endmodule

// File: rtl/wcb_line_buffer_chk.sv
module wcb_line_buffer_chk #(
    parameter int LINE_BYTES = 64,
    parameter int LINE_AW    = 26
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic                  st_ready,
    input logic                  snp_req,
    input logic [LINE_AW-1:0]    snp_line,
    input logic                  snp_valid,
    input logic                  snp_dirty,
    input logic                  inv_req,
    input logic                  mem_valid,
    input logic [LINE_AW-1:0]    mem_line,
    input logic [LINE_BYTES-1:0] mem_mask
);
    localparam logic [LINE_BYTES-1:0] ALL = {LINE_BYTES{1'b1}};

    // R1
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> !(snp_req || inv_req || mem_valid));
    // R2
    no_peer_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |-> (!snp_req && !inv_req));
    // R3
    inv_then_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |=> (mem_valid && mem_mask == ALL));
    // R3
    inv_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |=> $stable(mem_line));
    // R4
    no_snoop_with_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snp_req, inv_req, mem_valid}));
    // R5
    snoop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && !snp_valid) |=> (snp_req && $stable(snp_line)));
    // R6
    dirty_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && snp_valid && snp_dirty) |=> (mem_valid && mem_mask == ALL));
    // R7
    clean_partial_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && snp_valid && !snp_dirty) |=> (mem_valid && mem_mask != ALL));
    // R10
    write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> (!mem_valid && st_ready));
endmodule

bind wcb_line_buffer wcb_line_buffer_chk #(
    .LINE_BYTES(LINE_BYTES),
    .LINE_AW(LINE_AW)
) u_chk (.*);

// File: tb/wcb_line_buffer_bench.sv
`timescale 1ns/1ps
module wcb_line_buffer_bench;
    localparam int NB = 64;
    localparam int AW = 26;
    localparam int DW = NB * 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, st_valid, st_ready, flush_req;
    logic [AW-1:0] st_line, snp_line, inv_line, mem_line;
    logic [DW-1:0] st_data, snp_data, mem_data;
    logic [NB-1:0] st_be, mem_mask;
    logic          snp_req, snp_valid, snp_dirty, inv_req, mem_valid;

    wcb_line_buffer #(.LINE_BYTES(NB), .LINE_AW(AW)) u_wcb_line_buffer (.*);

    typedef struct {
        logic [AW-1:0] line;
        logic [DW-1:0] data;
        logic [NB-1:0] mask;
        bit            full;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] m_data;
    logic [NB-1:0] m_valid;
    logic [AW-1:0] m_line;
    bit            cfg_dirty;
    logic [DW-1:0] cfg_data;
    int            cfg_delay;
    int            total = 0, bad = 0, snp_rises = 0;
    bit            finished = 0;

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bits(logic [NB-1:0] m);
        logic [DW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = {8{m[i]}};
        return r;
    endfunction

    function automatic logic [DW-1:0] mkdata(logic [7:0] seed);
        logic [DW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = seed + 8'(i * 7);
        return r;
    endfunction

    task automatic push_partial(string tag);
        exp_t e;
        e.line = m_line; e.full = 0; e.tag = tag;
        if (cfg_dirty) begin
            e.mask = '1;
            e.data = (m_data & bits(m_valid)) | (cfg_data & ~bits(m_valid));
        end else begin
            e.mask = m_valid;
            e.data = m_data;
        end
        q.push_back(e);
        m_valid = '0;
    endtask

    task automatic do_store(logic [AW-1:0] line, logic [DW-1:0] data,
                            logic [NB-1:0] be, string tag);
        exp_t e;
        if (m_valid != '0 && line != m_line) push_partial({tag, " R8 drain"});
        @(negedge clk);
        st_valid = 1; st_line = line; st_data = data; st_be = be;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        st_valid = 0;
        if (be != '0) begin
            if (m_valid == '0) m_line = line;
            for (int i = 0; i < NB; i++)
                if (be[i]) begin
                    m_data[i*8 +: 8] = data[i*8 +: 8];
                    m_valid[i] = 1'b1;
                end
        end
        if (&m_valid) begin
            e.line = m_line; e.data = m_data; e.mask = '1; e.full = 1;
            e.tag = {tag, " R3 full"};
            q.push_back(e);
            m_valid = '0;
        end
    endtask

    task automatic do_flush(string tag);
        bit had = (m_valid != '0);
        logic [AW-1:0] ln = m_line;
        if (had) push_partial(tag);
        @(negedge clk);
        flush_req = 1;
        @(negedge clk);
        flush_req = 0;
        #1;
        if (had) begin
            chk(snp_req == 1, "R5 snoop raised", DW'(snp_req), DW'(1));
            chk(snp_line == ln, "R5 snoop line", DW'(snp_line), DW'(ln));
            chk(st_ready == 0, "R1 ready low while draining", DW'(st_ready), DW'(0));
            if (cfg_delay >= 2) begin
                @(negedge clk);
                #1;
                chk(snp_req == 1, "R5 snoop held", DW'(snp_req), DW'(1));
            end
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (q.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    // snoop responder
    initial begin
        int wcnt = 0;
        snp_valid = 0; snp_dirty = 0; snp_data = '0;
        forever begin
            @(negedge clk);
            snp_valid = 0;
            if (snp_req) begin
                wcnt++;
                if (wcnt >= cfg_delay) begin
                    snp_valid = 1; snp_dirty = cfg_dirty; snp_data = cfg_data;
                    wcnt = 0;
                end
            end else wcnt = 0;
        end
    end

    // monitor / scoreboard
    initial begin
        bit snp_prev = 0, inv_prev = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (snp_req && !snp_prev) snp_rises++;
                if (mem_valid) begin
                    if (q.size() == 0) begin
                        chk(0, "R10 unexpected write", DW'(mem_line), DW'(0));
                    end else begin
                        e = q.pop_front();
                        chk(mem_line == e.line, {e.tag, " line"}, DW'(mem_line), DW'(e.line));
                        chk(mem_mask == e.mask, {e.tag, " mask"}, DW'(mem_mask), DW'(e.mask));
                        chk(((mem_data ^ e.data) & bits(e.mask)) == '0, {e.tag, " data"},
                            mem_data & bits(e.mask), e.data & bits(e.mask));
                        chk(inv_prev == e.full, {e.tag, " invalidate before write"},
                            DW'(inv_prev), DW'(e.full));
                    end
                end
            end
            snp_prev = snp_req;
            inv_prev = inv_req;
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r0;
        rst_n = 0; st_valid = 0; st_line = '0; st_data = '0; st_be = '0; flush_req = 0;
        m_valid = '0; m_data = '0; m_line = '0;
        cfg_dirty = 0; cfg_data = '0; cfg_delay = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(st_ready == 1, "R11 ready after reset", DW'(st_ready), DW'(1));
        chk({snp_req, inv_req, mem_valid} == 3'b000, "R11 outputs idle",
            DW'({snp_req, inv_req, mem_valid}), DW'(0));

        // full line through three stores with overwrite; dirty peer ignored
        cfg_dirty = 1; cfg_data = {NB{8'hEE}};
        do_store(26'h0123, mkdata(8'h10), 64'h0000_0000_FFFF_FFFF, "R1 R4");
        do_store(26'h0123, mkdata(8'hA0), 64'h0000_0000_0000_00FF, "R9 overwrite");
        do_store(26'h0123, mkdata(8'h30), 64'hFFFF_FFFF_0000_0000, "R4 R9");
        wait_idle();
        chk(snp_rises == 0, "R2 R4 no snoop on full path", DW'(snp_rises), DW'(0));

        // partial clean
        cfg_dirty = 0; cfg_delay = 1;
        do_store(26'h0456, mkdata(8'h55), 64'h0000_F00F_0000_0081, "R1");
        r0 = snp_rises;
        chk(r0 == 0, "R2 no snoop before accept", DW'(r0), DW'(0));
        do_flush("R7 clean partial");
        wait_idle();

        // partial dirty with slow response
        cfg_dirty = 1; cfg_data = mkdata(8'hC3); cfg_delay = 3;
        do_store(26'h0789, mkdata(8'h07), 64'h8000_0000_00F0_0001, "R1");
        do_store(26'h0789, mkdata(8'h99), 64'h8000_0000_0000_0000, "R9");
        do_flush("R6 dirty merge");
        wait_idle();

        // different line forces drain
        cfg_dirty = 0; cfg_delay = 1;
        do_store(26'h0AAA, mkdata(8'h21), 64'h0000_0000_0000_000F, "R8 first");
        do_store(26'h0BBB, mkdata(8'h42), 64'h0000_0000_0000_00F0, "R8 second");
        cfg_dirty = 1; cfg_data = mkdata(8'h66);
        do_flush("R8 new line flushed");
        wait_idle();

        // idle flush and empty store are ignored
        r0 = snp_rises;
        do_store(26'h0CCC, mkdata(8'h01), 64'h0, "R10 empty");
        #1;
        chk(st_ready == 1, "R10 empty store stays idle", DW'(st_ready), DW'(1));
        do_flush("R10 idle flush");
        repeat (5) @(negedge clk);
        chk(snp_rises == r0, "R10 idle flush ignored", DW'(snp_rises), DW'(r0));

        // single store covering the whole line
        cfg_dirty = 1; cfg_data = '0;
        do_store(26'h0DDD, mkdata(8'h77), '1, "R3 single");
        wait_idle();
        #1;
        chk(st_ready == 1, "R10 ready after drain", DW'(st_ready), DW'(1));
        chk(q.size() == 0, "R10 all writes seen", DW'(q.size()), DW'(0));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule